// File: doc/BRIEF.md
# UART Receive Idle Timeout Timer

This block watches the receive side of a UART and reports when characters have stopped arriving while unread data is still in the receive FIFO. Software programs a delay as a count of whole character times. The block measures each character time in ticks of the one-bit baud strobe, so the delay follows the frame format and the baud rate. When the programmed count of idle character times has passed, the block raises a sticky timeout status bit and an interrupt request.

A new received character restarts the measurement. An empty FIFO holds the timer at zero and clears the status. A programmed value of zero switches the function off. After the block fires, it stays quiet until the idle period ends with a new character or with the FIFO draining. The status bit stays set until software reads it or the FIFO drains.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset, `status_o` and `irq_o` are 0.
- R2: One character time is L bit ticks, with L = 1 + (5 + `data_len_i`) + `parity_en_i` + (`stop2_i` ? 2 : 1). `data_len_i` codes 0..3 select 5..8 data bits, so L ranges from 7 to 12.
- R3: When the FIFO is not empty and `tmo_i` = N > 0, `status_o` rises at the clock edge that samples the (N*L)-th bit tick after the last `char_rx_i` strobe. It is still 0 after N*L-1 ticks.
- R4: A `char_rx_i` strobe clears all counting. A bit tick in the same cycle as the strobe is not counted.
- R5: While `tmo_i` is 0, `status_o` never rises and `irq_o` is never asserted.
- R6: While `fifo_empty_i` is 1, ticks are not counted and `status_o` is cleared on the next edge.
- R7: Once set, `status_o` stays 1 until a cycle with `status_rd_i` = 1 or `fifo_empty_i` = 1. If expiry falls in the same cycle as a read, the status is set.
- R8: The timer fires only once per idle period. After expiry, no further ticks set the status again until a new `char_rx_i` strobe or an empty FIFO.
- R9: With the default `IRQ_LEVEL` = 0, `irq_o` is a single-cycle pulse, asserted in exactly the cycle in which `status_o` first becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_i | input | TMO_W | Timeout in character times; 0 disables |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| data_len_i | input | 2 | Data length code, 0..3 = 5..8 bits |
| parity_en_i | input | 1 | Parity bit present |
| stop2_i | input | 1 | Two stop bits when 1 |
| char_rx_i | input | 1 | Character placed into the FIFO |
| fifo_empty_i | input | 1 | Receive FIFO empty |
| status_rd_i | input | 1 | Status read strobe; clears status |
| status_o | output | 1 | Sticky timeout status |
| irq_o | output | 1 | Timeout interrupt request |

## Verification
The assertions assume that the strobe inputs `bit_tick_i`, `char_rx_i` and `status_rd_i` are single-cycle events. They also assume that the frame format and `tmo_i` only change between idle periods, because a mid-count change would make the elapsed count ambiguous. The stimulus keeps within these limits: it changes the configuration only after an empty-FIFO cycle or a character strobe, and it drives each strobe high for exactly one cycle, with ticks separated by idle cycles.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
   localparam int unsigned MIN_DATA  = 5;
   localparam int unsigned MAX_FRAME = 1 + 8 + 1 + 2;
   localparam int unsigned FRAME_W   = $clog2(MAX_FRAME + 1);

   typedef struct packed {
      logic [1:0] dlen;
      logic       par;
      logic       stop2;
   } frame_t;

   // bits per character: start + data + optional parity + stop(s)
   function automatic logic [FRAME_W-1:0] frame_bits(frame_t f);
      logic [FRAME_W-1:0] n;
      n = FRAME_W'(1 + MIN_DATA + 1)
        + FRAME_W'(f.dlen) + FRAME_W'(f.par) + FRAME_W'(f.stop2);
      return n;
   endfunction
endpackage

// File: rtl/rxto_bit_cnt.sv
module rxto_bit_cnt #(
   parameter int unsigned BW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          tick,
   input  logic [BW-1:0] last_idx,
   output logic          wrap
);
   logic [BW-1:0] cnt;

   assign wrap = tick && !clear && (cnt >= last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clear)  cnt <= '0;
      else if (tick)   cnt <= wrap ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/rxto_char_cnt.sv
module rxto_char_cnt #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic         expire
);
   logic [W-1:0] cnt;
   logic [W-1:0] last;

   assign last   = limit - 1'b1;
   assign expire = step && !clear && (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clear)  cnt <= '0;
      else if (step)   cnt <= expire ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
   import rxto_pkg::*;
#(
   parameter int unsigned TMO_W     = 8,
   parameter bit          IRQ_LEVEL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMO_W-1:0] tmo_i,
   input  logic             bit_tick_i,
   input  logic [1:0]       data_len_i,
   input  logic             parity_en_i,
   input  logic             stop2_i,
   input  logic             char_rx_i,
   input  logic             fifo_empty_i,
   input  logic             status_rd_i,
   output logic             status_o,
   output logic             irq_o
);
   localparam int unsigned BW = FRAME_W;

   generate
      if (TMO_W < 2 || TMO_W > 16) begin : g_bad_w
         $error("rx_idle_timer: TMO_W must be 2..16");
      end
   endgenerate

   frame_t          fmt;
   logic [BW-1:0]   last_idx;
   logic            fired_q;
   logic            active;
   logic            clear;
   logic            char_step;
   logic            expire;
   logic            status_q;

   assign fmt      = '{dlen: data_len_i, par: parity_en_i, stop2: stop2_i};
   assign last_idx = frame_bits(fmt) - 1'b1;
   assign active   = !fifo_empty_i && (tmo_i != '0) && !fired_q;
   assign clear    = char_rx_i || !active;

   rxto_bit_cnt #(.BW(BW)) u_bits (
      .clk(clk), .rst_n(rst_n), .clear(clear), .tick(bit_tick_i),
      .last_idx(last_idx), .wrap(char_step)
   );

   rxto_char_cnt #(.W(TMO_W)) u_chars (
      .clk(clk), .rst_n(rst_n), .clear(clear), .step(char_step),
      .limit(tmo_i), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          fired_q <= 1'b0;
      else if (char_rx_i || fifo_empty_i)  fired_q <= 1'b0;
      else if (expire)                     fired_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              status_q <= 1'b0;
      else if (expire)                         status_q <= 1'b1;
      else if (status_rd_i || fifo_empty_i)    status_q <= 1'b0;
   end

   assign status_o = status_q;

   generate
      if (IRQ_LEVEL) begin : g_irq_level
         assign irq_o = status_q;
      end else begin : g_irq_pulse
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= expire;
         end
         assign irq_o = pulse_q;
      end
   endgenerate
endmodule

// File: rtl/rx_idle_timer_chk.sv
module rx_idle_timer_chk #(
   parameter int unsigned TMO_W     = 8,
   parameter bit          IRQ_LEVEL = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [TMO_W-1:0] tmo_i,
   input logic             char_rx_i,
   input logic             fifo_empty_i,
   input logic             status_rd_i,
   input logic             status_o,
   input logic             irq_o
);
   // R5: a zero setting never produces a rising status
   a_r5_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_o && tmo_i == '0) |=> !status_o);

   // R6: an empty FIFO clears the status
   a_r6_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty_i |=> !status_o);

   // R4: a character strobe cannot be followed by an expiry
   a_r4_strobe_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (char_rx_i && !status_o) |=> !status_o);

   // R7: status is sticky without a read or an empty FIFO
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o && !status_rd_i && !fifo_empty_i) |=> status_o);

   generate
      if (!IRQ_LEVEL) begin : g_pulse_chk
         // R9: pulse is one cycle wide and coincides with status rising
         a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |=> !irq_o);
         a_r9_irq_with_status: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> status_o);
      end
   endgenerate
endmodule

bind rx_idle_timer rx_idle_timer_chk #(.TMO_W(TMO_W), .IRQ_LEVEL(IRQ_LEVEL)) u_chk (.*);

// File: tb/rx_idle_timer_test.sv
module rx_idle_timer_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] tmo = '0;
   logic       tick = 1'b0;
   logic [1:0] dlen = '0;
   logic       par = 1'b0;
   logic       st2 = 1'b0;
   logic       crx = 1'b0;
   logic       empty = 1'b1;
   logic       rd = 1'b0;
   logic       status, irq;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_idle_timer uut (
      .clk(clk), .rst_n(rst_n), .tmo_i(tmo), .bit_tick_i(tick),
      .data_len_i(dlen), .parity_en_i(par), .stop2_i(st2),
      .char_rx_i(crx), .fifo_empty_i(empty), .status_rd_i(rd),
      .status_o(status), .irq_o(irq)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic pulse_crx();
      @(negedge clk) crx = 1'b1;
      @(negedge clk) crx = 1'b0;
   endtask

   task automatic pulse_rd();
      @(negedge clk) rd = 1'b1;
      @(negedge clk) rd = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk) empty = 1'b1;
      @(negedge clk) empty = 1'b0;
   endtask

   function automatic int frame_len(input int d, input int p, input int s);
      return 1 + (5 + d) + p + (s ? 2 : 1);
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int tvals[4] = '{1, 2, 3, 7};
      int len, total;
      repeat (3) @(negedge clk);
      check("R1 status", status, 1'b0);
      check("R1 irq", irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 status after release", status, 1'b0);

      // R2/R3/R9: sweep all frame formats and several timeout values
      for (int f = 0; f < 16; f++) begin
         for (int k = 0; k < 4; k++) begin
            dlen = 2'(f & 3); par = f[2]; st2 = f[3];
            tmo = 8'(tvals[k]);
            drain();
            pulse_crx();
            len = frame_len(f & 3, f[2], f[3]);
            total = tvals[k] * len;
            ticks(total - 1);
            check("R3 not yet", status, 1'b0);
            ticks(1);
            check("R2/R3 expiry", status, 1'b1);
            check("R9 irq pulse", irq, 1'b1);
            @(negedge clk);
            check("R9 irq drops", irq, 1'b0);
            check("R7 held", status, 1'b1);
            pulse_rd();
            check("R7 read clears", status, 1'b0);
            if (k == 1) begin
               ticks(total + 3);
               check("R8 no refire", status, 1'b0);
               check("R8 no irq", irq, 1'b0);
            end
         end
      end

      // R4: strobe mid-count restarts; tick coincident with strobe ignored
      dlen = 2'd3; par = 1'b1; st2 = 1'b1; tmo = 8'd2;  // L = 12
      drain(); pulse_crx();
      ticks(20);
      @(negedge clk) begin crx = 1'b1; tick = 1'b1; end
      @(negedge clk) begin crx = 1'b0; tick = 1'b0; end
      ticks(23);
      check("R4 restarted, not yet", status, 1'b0);
      ticks(1);
      check("R4 expiry after restart", status, 1'b1);

      // R6: empty FIFO clears status and stops counting
      @(negedge clk) empty = 1'b1;
      @(negedge clk);
      check("R6 empty clears", status, 1'b0);
      ticks(60);
      check("R6 no count while empty", status, 1'b0);
      empty = 1'b0;
      ticks(23);
      check("R6 counting from zero, not yet", status, 1'b0);
      ticks(1);
      check("R6 expiry after refill", status, 1'b1);

      // R7: expiry in same cycle as a read leaves status set
      pulse_rd();
      pulse_crx();
      ticks(23);
      @(negedge clk) begin tick = 1'b1; rd = 1'b1; end
      @(negedge clk) begin tick = 1'b0; rd = 1'b0; end
      check("R7 set wins over read", status, 1'b1);

      // R5: zero setting disables
      tmo = 8'd0;
      drain(); pulse_crx();
      ticks(300);
      check("R5 zero never sets", status, 1'b0);
      check("R5 zero no irq", irq, 1'b0);

      // R3: maximum setting, L = 7
      tmo = 8'd255; dlen = 2'd0; par = 1'b0; st2 = 1'b0;
      drain(); pulse_crx();
      ticks(255 * 7 - 1);
      check("R3 max not yet", status, 1'b0);
      ticks(1);
      check("R3 max expiry", status, 1'b1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule